// File: doc/BRIEF.md
# Streaming Hamming ECC Engine for 512-Byte Sectors

The engine computes a 3-byte single-error-correcting Hamming code over a 512-byte flash sector. The sector arrives one byte at a time, and a byte is taken on every cycle that `valid_i` is high. A start-of-sector strobe may come with or without a byte. The engine folds each byte into two running values. The first is the XOR of all bytes, which gives the column parities. The second is the XOR of the in-sector index of every byte with odd parity, which gives the row parities. When the last byte of a sector has been taken, the engine packs twelve parity pairs into three inverted code bytes and raises a one-cycle valid strobe. The code stays on `code_o` until the next sector completes.

The check path compares a stored code against the code of the sector that completed last. It reports one of four outcomes one cycle after the request:

- the codes match;
- a single data bit is wrong, given as a byte index and a bit index;
- a single bit of the stored code is wrong and the data is good;
- the error cannot be corrected.

Writing the corrected data back is left to the caller.

Top module: `ecc_engine`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `code_valid_o` and `res_valid_o` are low and `code_o` is 24'hFFFFFF, which is the code of an all-zero sector.
- R2: `code_valid_o` is high for exactly one cycle: the cycle after the 512th byte of a sector is accepted. Idle cycles between bytes do not change the result.
- R3: Bits 23:16 of `code_o` form byte 2. Its bits 7..2 hold the complemented parities of the XOR of all bytes under these masks, in this order: 0xF0, 0x0F, 0xCC, 0x33, 0xAA, 0x55.
- R4: Let R be the 9-bit XOR of the indices of all odd-parity bytes, and let T be the parity of all sector bits. For row pair j (0..8), the non-primed bit is R[j] and the primed bit is R[j]^T. Byte 0 (bits 7:0) holds pairs 0..3, with pair j in bits 2j+1 and 2j. Byte 1 (bits 15:8) holds pairs 4..7 in the same way. Byte 2 holds pair 8 in bits 1 and 0. The non-primed bit always sits in the odd position.
- R5: Every code bit is stored complemented. A sector holding 0x01 only at index 0 gives 24'hAAAAAA, and one holding 0x80 only at index 511 gives 24'h555555.
- R6: A cycle with `sos_i` high discards any partial sector. If `valid_i` is high in the same cycle, that byte becomes byte 0 of the new sector. If it is low, no byte is taken and no code is produced.
- R7: After a sector completes, the next accepted byte starts a new sector without any `sos_i`.
- R8: `res_valid_o` is high exactly on the cycle after `chk_i`. If `stored_code_i` equals `code_o` in the request cycle, `status_o` is 0 (clean).
- R9: If the two codes differ in exactly one bit of every one of the 12 pairs, `status_o` is 1 (corrected). In that case `byte_idx_o` is the index of the bad byte and `bit_idx_o` is the index of the bad bit.
- R10: If the two codes differ in exactly one bit, `status_o` is 2 (code error only).
- R11: Any other difference gives `status_o` 3 (uncorrectable). For every status other than 1, both indices are 0.
- R12: `code_o` changes only on the cycle where `code_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sos_i | input | 1 | Start of sector; discards any partial sector |
| valid_i | input | 1 | `data_i` carries a sector byte |
| data_i | input | 8 | Sector byte |
| code_valid_o | output | 1 | One-cycle strobe when a new code is ready |
| code_o | output | 24 | Last code computed, as {byte2, byte1, byte0} |
| chk_i | input | 1 | Check request |
| stored_code_i | input | 24 | Stored code to compare with `code_o` |
| res_valid_o | output | 1 | Check result strobe |
| status_o | output | 2 | 0 clean, 1 corrected, 2 code error only, 3 uncorrectable |
| byte_idx_o | output | 9 | Index of the bad byte when status is 1 |
| bit_idx_o | output | 3 | Index of the bad bit when status is 1 |

## Verification
The bench aims at three kinds of corner case.

Single data-bit flips at the first and last byte and at bit 0 and bit 7 each need a correct byte and bit index. A decoder that reads the even bits of each pair, or that mixes up the column and row fields, would report the wrong location.

A single flipped stored-code bit and a double data-bit flip sit on either side of the correctable pattern. A decode that checks only the total number of differing bits would call a two-bit data error correctable.

A `sos_i` that comes without a byte, a partial sector that is cut short, and sectors streamed back to back without `sos_i` all test the byte counter. If the counter failed to restart, the strobe would land in the wrong cycle or the code would cover bytes from the wrong sector.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    // column parity pairs derived from the byte-wide XOR (bit index width)
    localparam int COL_PAIRS = 3;
    localparam int BYTE_W    = 8;

    typedef enum logic [1:0] {
        ST_CLEAN     = 2'd0,
        ST_FIXED     = 2'd1,
        ST_CODE_ONLY = 2'd2,
        ST_FATAL     = 2'd3
    } ecc_status_e;

    // Mask of the bit positions whose index has bit k set.
    function automatic logic [BYTE_W-1:0] col_mask(input int k);
        logic [BYTE_W-1:0] m;
        for (int b = 0; b < BYTE_W; b++) begin
            m[b] = ((b >> k) & 1) != 0;
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_word_build.sv
module ecc_word_build
    import ecc_pkg::*;
#(
    parameter int ROW_BITS = 9,
    localparam int PAIRS   = ROW_BITS + COL_PAIRS,
    localparam int WORD_W  = 2 * PAIRS,
    localparam int LOW_W   = 2 * COL_PAIRS
) (
    input  logic [BYTE_W-1:0]   gpar_i,
    input  logic [ROW_BITS-1:0] rowp_i,
    output logic [WORD_W-1:0]   word_o
);

    logic total;

    // Pair k of the word: odd bit = plain parity, even bit = primed parity.
    always_comb begin
        total  = ^gpar_i;
        word_o = '0;
        for (int k = 0; k < COL_PAIRS; k++) begin
            word_o[2*k+1] = ^(gpar_i & col_mask(k));
            word_o[2*k]   = ^(gpar_i & ~col_mask(k));
        end
        for (int j = 0; j < ROW_BITS; j++) begin
            word_o[LOW_W+2*j+1] = rowp_i[j];
            word_o[LOW_W+2*j]   = rowp_i[j] ^ total;
        end
    end

endmodule

// File: rtl/ecc_accum.sv
module ecc_accum
    import ecc_pkg::*;
#(
    parameter int ROW_BITS = 9,
    localparam int PAIRS   = ROW_BITS + COL_PAIRS,
    localparam int WORD_W  = 2 * PAIRS,
    localparam int LOW_W   = 2 * COL_PAIRS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sos_i,
    input  logic                valid_i,
    input  logic [BYTE_W-1:0]   data_i,
    output logic                code_valid_o,
    output logic [WORD_W-1:0]   code_o
);

    localparam logic [ROW_BITS-1:0] LAST_IDX = '1;

    typedef struct packed {
        logic [ROW_BITS-1:0] idx;
        logic [BYTE_W-1:0]   gpar;
        logic [ROW_BITS-1:0] rowp;
        logic [WORD_W-1:0]   code;
        logic                done;
    } acc_t;

    acc_t st_d, st_q;

    logic [ROW_BITS-1:0] base_idx, base_rowp, sum_rowp;
    logic [BYTE_W-1:0]   base_gpar, sum_gpar;
    logic [WORD_W-1:0]   word;

    // Sector-start strobe discards partial state before this byte folds in.
    always_comb begin
        base_idx  = sos_i ? '0 : st_q.idx;
        base_gpar = sos_i ? '0 : st_q.gpar;
        base_rowp = sos_i ? '0 : st_q.rowp;
        sum_gpar  = base_gpar ^ data_i;
        sum_rowp  = base_rowp ^ ((^data_i) ? base_idx : '0);
    end

    ecc_word_build #(.ROW_BITS(ROW_BITS)) u_build (
        .gpar_i (sum_gpar),
        .rowp_i (sum_rowp),
        .word_o (word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.idx  = base_idx;
        st_d.gpar = base_gpar;
        st_d.rowp = base_rowp;
        if (valid_i) begin
            if (base_idx == LAST_IDX) begin
                st_d.idx  = '0;
                st_d.gpar = '0;
                st_d.rowp = '0;
                st_d.done = 1'b1;
                // rotate so the column pairs land in the top byte, then complement
                st_d.code = ~{word[LOW_W-1:0], word[WORD_W-1:LOW_W]};
            end else begin
                st_d.idx  = base_idx + 1'b1;
                st_d.gpar = sum_gpar;
                st_d.rowp = sum_rowp;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.code <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_valid_o = st_q.done;
    assign code_o       = st_q.code;

endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
    import ecc_pkg::*;
#(
    parameter int ROW_BITS = 9,
    localparam int PAIRS   = ROW_BITS + COL_PAIRS,
    localparam int WORD_W  = 2 * PAIRS,
    localparam int LOW_W   = 2 * COL_PAIRS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chk_i,
    input  logic [WORD_W-1:0]    stored_i,
    input  logic [WORD_W-1:0]    fresh_i,
    output logic                 res_valid_o,
    output logic [1:0]           status_o,
    output logic [ROW_BITS-1:0]  byte_idx_o,
    output logic [COL_PAIRS-1:0] bit_idx_o
);

    typedef struct packed {
        logic                 rv;
        ecc_status_e          status;
        logic [ROW_BITS-1:0]  byte_idx;
        logic [COL_PAIRS-1:0] bit_idx;
    } res_t;

    res_t r_d, r_q;

    logic [WORD_W-1:0] w_old, w_new, diff;
    logic [PAIRS-1:0]  odd_bits, split;
    logic              all_split, lone_bit;

    always_comb begin
        // undo the byte rotation: ascending pair order, pair 0 at the bottom
        w_old = {stored_i[WORD_W-LOW_W-1:0], stored_i[WORD_W-1:WORD_W-LOW_W]};
        w_new = {fresh_i[WORD_W-LOW_W-1:0], fresh_i[WORD_W-1:WORD_W-LOW_W]};
        diff  = w_old ^ w_new;
        for (int k = 0; k < PAIRS; k++) begin
            odd_bits[k] = diff[2*k+1];
            split[k]    = diff[2*k+1] ^ diff[2*k];
        end
        all_split = &split;
        lone_bit  = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
    end

    always_comb begin
        r_d    = r_q;
        r_d.rv = chk_i;
        if (chk_i) begin
            r_d.byte_idx = '0;
            r_d.bit_idx  = '0;
            if (diff == '0) begin
                r_d.status = ST_CLEAN;
            end else if (all_split) begin
                r_d.status   = ST_FIXED;
                r_d.bit_idx  = odd_bits[COL_PAIRS-1:0];
                r_d.byte_idx = odd_bits[PAIRS-1:COL_PAIRS];
            end else if (lone_bit) begin
                r_d.status = ST_CODE_ONLY;
            end else begin
                r_d.status = ST_FATAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.status <= ST_CLEAN;
        end else begin
            r_q <= r_d;
        end
    end

    assign res_valid_o = r_q.rv;
    assign status_o    = r_q.status;
    assign byte_idx_o  = r_q.byte_idx;
    assign bit_idx_o   = r_q.bit_idx;

endmodule

// File: rtl/ecc_engine.sv
module ecc_engine
    import ecc_pkg::*;
#(
    parameter int ROW_BITS = 9,
    localparam int WORD_W  = 2 * (ROW_BITS + COL_PAIRS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sos_i,
    input  logic                 valid_i,
    input  logic [7:0]           data_i,
    output logic                 code_valid_o,
    output logic [WORD_W-1:0]    code_o,
    input  logic                 chk_i,
    input  logic [WORD_W-1:0]    stored_code_i,
    output logic                 res_valid_o,
    output logic [1:0]           status_o,
    output logic [ROW_BITS-1:0]  byte_idx_o,
    output logic [2:0]           bit_idx_o
);

    ecc_accum #(.ROW_BITS(ROW_BITS)) u_accum (
        .clk          (clk),
        .rst_n        (rst_n),
        .sos_i        (sos_i),
        .valid_i      (valid_i),
        .data_i       (data_i),
        .code_valid_o (code_valid_o),
        .code_o       (code_o)
    );

    ecc_syndrome #(.ROW_BITS(ROW_BITS)) u_syndrome (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_i       (chk_i),
        .stored_i    (stored_code_i),
        .fresh_i     (code_o),
        .res_valid_o (res_valid_o),
        .status_o    (status_o),
        .byte_idx_o  (byte_idx_o),
        .bit_idx_o   (bit_idx_o)
    );

endmodule

// File: rtl/ecc_engine_chk.sv
module ecc_engine_chk
    import ecc_pkg::*;
#(
    parameter int ROW_BITS = 9,
    localparam int WORD_W  = 2 * (ROW_BITS + COL_PAIRS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sos_i,
    input logic                valid_i,
    input logic                code_valid_o,
    input logic [WORD_W-1:0]   code_o,
    input logic                chk_i,
    input logic [WORD_W-1:0]   stored_code_i,
    input logic                res_valid_o,
    input logic [1:0]          status_o,
    input logic [ROW_BITS-1:0] byte_idx_o,
    input logic [2:0]          bit_idx_o
);

    // R2: a new code only follows an accepted byte
    a_r2_code_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |-> $past(valid_i));

    // R2: the strobe lasts a single cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |=> !code_valid_o);

    // R6: a sector-start strobe without a byte never completes a sector
    a_r6_bare_sos_no_code: assert property (@(posedge clk) disable iff (!rst_n)
        (sos_i && !valid_i) |=> !code_valid_o);

    // R12: the code output holds between completions
    a_r12_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid_o |-> $stable(code_o));

    // R8: result strobe exactly follows a request
    a_r8_result_after_request: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(chk_i));

    // R8: equal codes report clean
    a_r8_equal_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_i && (stored_code_i == code_o)) |=> (res_valid_o && status_o == ST_CLEAN));

    // R11: indices are zero unless the status is corrected
    a_r11_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && status_o != ST_FIXED) |-> (byte_idx_o == '0 && bit_idx_o == '0));

endmodule

bind ecc_engine ecc_engine_chk #(.ROW_BITS(ROW_BITS)) u_ecc_engine_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sos_i         (sos_i),
    .valid_i       (valid_i),
    .code_valid_o  (code_valid_o),
    .code_o        (code_o),
    .chk_i         (chk_i),
    .stored_code_i (stored_code_i),
    .res_valid_o   (res_valid_o),
    .status_o      (status_o),
    .byte_idx_o    (byte_idx_o),
    .bit_idx_o     (bit_idx_o)
);

// File: tb/test_ecc_engine.sv
module test_ecc_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sos_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        chk_i = 1'b0;
    logic [23:0] stored_code_i = '0;
    logic        code_valid_o;
    logic [23:0] code_o;
    logic        res_valid_o;
    logic [1:0]  status_o;
    logic [8:0]  byte_idx_o;
    logic [2:0]  bit_idx_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ecc_engine i_ecc_engine (
        .clk(clk), .rst_n(rst_n), .sos_i(sos_i), .valid_i(valid_i), .data_i(data_i),
        .code_valid_o(code_valid_o), .code_o(code_o), .chk_i(chk_i),
        .stored_code_i(stored_code_i), .res_valid_o(res_valid_o), .status_o(status_o),
        .byte_idx_o(byte_idx_o), .bit_idx_o(bit_idx_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference code, built from the requirement text byte by byte.
    function automatic logic [23:0] ref_code(input logic [7:0] s[$]);
        logic [7:0] g = '0;
        logic [8:0] r = '0;
        logic       t;
        logic [7:0] b0 = '0, b1 = '0, b2 = '0;
        for (int i = 0; i < s.size(); i++) begin
            g ^= s[i];
            if ($countones(s[i]) % 2 == 1) r ^= 9'(i);
        end
        t = ^g;
        b2[7] = ^(g & 8'hF0); b2[6] = ^(g & 8'h0F);
        b2[5] = ^(g & 8'hCC); b2[4] = ^(g & 8'h33);
        b2[3] = ^(g & 8'hAA); b2[2] = ^(g & 8'h55);
        b2[1] = r[8];         b2[0] = r[8] ^ t;
        for (int j = 0; j < 4; j++) begin
            b0[2*j+1] = r[j];   b0[2*j] = r[j] ^ t;
            b1[2*j+1] = r[j+4]; b1[2*j] = r[j+4] ^ t;
        end
        return ~{b2, b1, b0};
    endfunction

    // ---------------- cycle-by-cycle reference model ----------------
    logic [7:0]  mq[$];
    logic        exp_cv = 1'b0;
    logic        exp_rv = 1'b0;
    logic [23:0] exp_code = 24'hFFFFFF;

    always @(negedge clk) begin
        if (!rst_n) begin
            mq.delete();
            exp_cv = 1'b0;
            exp_rv = 1'b0;
            exp_code = 24'hFFFFFF;
        end else begin
            check(code_valid_o === exp_cv, "R2", "code_valid_o", 32'(code_valid_o), 32'(exp_cv));
            check(code_o === exp_code, "R12", "code_o", 32'(code_o), 32'(exp_code));
            check(res_valid_o === exp_rv, "R8", "res_valid_o", 32'(res_valid_o), 32'(exp_rv));
            exp_cv = 1'b0;
            exp_rv = chk_i;
            if (sos_i) mq.delete();
            if (valid_i) begin
                mq.push_back(data_i);
                if (mq.size() == 512) begin
                    exp_code = ref_code(mq);
                    exp_cv = 1'b1;
                    mq.delete();
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [7:0] sec[512];
    logic [7:0] orig[512];

    function automatic logic [23:0] code_of_sec();
        logic [7:0] q[$];
        for (int i = 0; i < 512; i++) q.push_back(sec[i]);
        return ref_code(q);
    endfunction

    task automatic stream(input int count, input bit with_sos, input bit gaps);
        for (int i = 0; i < count; i++) begin
            @(posedge clk); #1;
            valid_i = 1'b1;
            data_i  = sec[i];
            sos_i   = with_sos && (i == 0);
            if (gaps && (i % 7 == 3)) begin
                @(posedge clk); #1;
                valid_i = 1'b0;
                sos_i   = 1'b0;
            end
        end
        @(posedge clk); #1;
        valid_i = 1'b0;
        sos_i   = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic run_check(input logic [23:0] stored, input logic [1:0] st,
                             input logic [8:0] bidx, input logic [2:0] bit_i, input string req);
        @(posedge clk); #1;
        chk_i = 1'b1;
        stored_code_i = stored;
        @(posedge clk); #1;
        chk_i = 1'b0;
        @(negedge clk);
        check(status_o === st, req, "status_o", 32'(status_o), 32'(st));
        check(byte_idx_o === bidx, req, "byte_idx_o", 32'(byte_idx_o), 32'(bidx));
        check(bit_idx_o === bit_i, req, "bit_idx_o", 32'(bit_idx_o), 32'(bit_i));
    endtask

    task automatic fill_random();
        for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
    endtask

    task automatic fill_zero();
        for (int i = 0; i < 512; i++) sec[i] = 8'h00;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [23:0] good;
        void'($urandom(32'h5eed));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(code_valid_o === 1'b0, "R1", "code_valid_o", 32'(code_valid_o), 0);
        check(res_valid_o === 1'b0, "R1", "res_valid_o", 32'(res_valid_o), 0);
        check(code_o === 24'hFFFFFF, "R1", "code_o", 32'(code_o), 32'hFFFFFF);
        rst_n = 1'b1;

        // R5: all-zero sector, then the two single-byte patterns
        fill_zero();
        stream(512, 1'b1, 1'b0);
        check(code_o === 24'hFFFFFF, "R5", "zero sector", 32'(code_o), 32'hFFFFFF);
        sec[0] = 8'h01;
        stream(512, 1'b1, 1'b0);
        check(code_o === 24'hAAAAAA, "R5", "0x01 at byte 0", 32'(code_o), 32'hAAAAAA);
        sec[0] = 8'h00;
        sec[511] = 8'h80;
        stream(512, 1'b1, 1'b1);
        check(code_o === 24'h555555, "R5", "0x80 at byte 511", 32'(code_o), 32'h555555);

        // R3 R4: random sectors, some with idle gaps
        for (int n = 0; n < 4; n++) begin
            fill_random();
            stream(512, 1'b1, n[0]);
            good = code_of_sec();
            check(code_o === good, "R3", "random sector code", 32'(code_o), 32'(good));
        end

        // R8: matching stored code
        run_check(code_o, 2'd0, 9'd0, 3'd0, "R8");

        // R9: single data-bit flips at several places
        fill_random();
        for (int i = 0; i < 512; i++) orig[i] = sec[i];
        good = code_of_sec();
        begin
            int locs[4][2] = '{'{0, 0}, '{511, 7}, '{258, 3}, '{85, 5}};
            for (int e = 0; e < 4; e++) begin
                for (int i = 0; i < 512; i++) sec[i] = orig[i];
                sec[locs[e][0]][locs[e][1]] = ~sec[locs[e][0]][locs[e][1]];
                stream(512, 1'b1, 1'b0);
                run_check(good, 2'd1, 9'(locs[e][0]), 3'(locs[e][1]), "R9");
            end
        end

        // R10: single stored-code bit flips, data intact
        for (int i = 0; i < 512; i++) sec[i] = orig[i];
        stream(512, 1'b1, 1'b0);
        begin
            int kbits[4] = '{0, 7, 12, 23};
            for (int e = 0; e < 4; e++)
                run_check(good ^ (24'd1 << kbits[e]), 2'd2, 9'd0, 3'd0, "R10");
        end

        // R11: double errors
        run_check(good ^ 24'h000003, 2'd3, 9'd0, 3'd0, "R11");
        sec[10][0] = ~sec[10][0];
        sec[10][1] = ~sec[10][1];
        stream(512, 1'b1, 1'b0);
        run_check(good, 2'd3, 9'd0, 3'd0, "R11");
        for (int i = 0; i < 512; i++) sec[i] = orig[i];
        sec[3][4] = ~sec[3][4];
        sec[300][4] = ~sec[300][4];
        stream(512, 1'b1, 1'b0);
        run_check(good, 2'd3, 9'd0, 3'd0, "R11");

        // R6: partial sector abandoned by a start strobe carrying a byte
        fill_random();
        stream(100, 1'b1, 1'b0);
        fill_random();
        stream(512, 1'b1, 1'b0);
        good = code_of_sec();
        check(code_o === good, "R6", "sos with byte restarts", 32'(code_o), 32'(good));
        // R6: bare start strobe
        stream(50, 1'b0, 1'b0);
        @(posedge clk); #1;
        sos_i = 1'b1;
        @(posedge clk); #1;
        sos_i = 1'b0;
        fill_random();
        stream(512, 1'b0, 1'b1);
        good = code_of_sec();
        check(code_o === good, "R6", "bare sos restarts", 32'(code_o), 32'(good));

        // R7: two sectors back to back, only the first flagged
        fill_random();
        stream(512, 1'b1, 1'b0);
        fill_random();
        stream(512, 1'b0, 1'b0);
        good = code_of_sec();
        check(code_o === good, "R7", "second sector code", 32'(code_o), 32'(good));

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule